// File: doc/BRIEF.md
# RTC Register Front End

This block sits between a byte-level two-wire target (the part that handles the SCL/SDA bit timing and address matching) and the registers of a real-time clock. The target reports decoded events: a write transfer has started, a read transfer has started, a byte has been received, or a byte must be supplied for transmission. The block turns these events into register accesses through a single pointer that advances on its own after each byte.

A write transfer opens with an address byte. Its high nibble sets the pointer and its low nibble is kept as a transfer-format code for the rest of the system. Later bytes go to the register at the pointer. Bytes aimed at the seven time fields (indices 0 to 6) are passed to the external timekeeper as write strobes. Bytes aimed at indices 7 to 15 are kept in local storage.

A read transfer first copies the live time fields into snapshot registers 0 to 6 and moves the pointer to index 15. The burst then walks 15, 0, 1, 2 and so on, so the host sees one consistent time value even if the clock ticks during the transfer.

Top module: `rtc_bus_frontend`

## Requirements
- R1: While reset is asserted, all 16 registers read as zero, the pointer is 0, no address byte is pending, the format code is 0 and no time write strobe is raised.
- R2: The first byte received after a write start is an address byte. Bits 7:4 load the pointer and bits 3:0 appear on `xfer_fmt` from the next cycle. No register is written by that byte.
- R3: Each later received byte is written at the pointer, and then the pointer advances by one. It wraps from 15 to 0.
- R4: A data byte at pointer 0 to 6 raises `time_wr_en` in the same cycle. `time_wr_idx` equals the pointer and `time_wr_data` equals the byte. Local storage is left unchanged.
- R5: A data byte at pointer 7 to 15 is stored at that index and raises no time write strobe. Indices 7 to 15 change only through such writes.
- R6: A read start copies field i of `time_now` (bits 8i+7:8i) into register i for i = 0 to 6, and sets the pointer to 15.
- R7: While `tx_req` is high, `tx_byte` shows the register at the pointer. The pointer then advances by one with wraparound, so a burst after a read start returns indices 15, 0, 1, and so on.
- R8: Registers 0 to 6 change only on a read start. Changes on `time_now` during a read burst do not alter the bytes returned.
- R9: A write transfer that ends after its address byte leaves all 16 registers unchanged.
- R10: `dev_addr` reports the 7-bit bus address parameter, which defaults to 0x32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Write transfer started (one-cycle pulse) |
| rd_start | input | 1 | Read transfer started (one-cycle pulse) |
| rx_valid | input | 1 | Received byte on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Byte to transmit is consumed this cycle |
| tx_byte | output | 8 | Register at the pointer |
| xfer_fmt | output | 4 | Saved transfer-format code |
| time_now | input | 56 | Live time fields, field i at bits 8i+7:8i |
| time_wr_en | output | 1 | Time field write strobe |
| time_wr_idx | output | 3 | Time field index being written |
| time_wr_data | output | 8 | Time field write value |
| dev_addr | output | 7 | Configured 7-bit bus address |

## Verification
The bound checker checks on every cycle how the pointer responds to each event: it loads on an address byte, is forced to 15 on a read start, and advances on data and transmit bytes. It also checks that time writes only happen below index 7, that the snapshot changes only on a read start, and that general registers change only when written. The directed scenarios cover what needs a whole transfer to observe. These are the order of bytes in a read burst, wraparound at both ends, stores landing at the expected index, an address-only write leaving the contents untouched, and a snapshot that stays frozen while `time_now` moves.

// File: rtl/rtc_fe_pkg.sv
package rtc_fe_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_RD_START,
    OP_WR_START,
    OP_ADDR,
    OP_DATA,
    OP_TX
  } fe_op_t;
endpackage

// File: rtl/rtc_fe_ptr.sv
module rtc_fe_ptr
  import rtc_fe_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DW       = 8,
  parameter int FMT_W    = 4,
  localparam int PW      = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          rd_start,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_req,
  output logic [PW-1:0] ptr_q,
  output logic [FMT_W-1:0] fmt_q,
  output logic          pend_q,
  output logic          data_we,
  output logic          snap_en
);
  fe_op_t           op;
  logic [PW-1:0]    ptr_d;
  logic [FMT_W-1:0] fmt_d;
  logic             pend_d;

  // event decode, read start has priority over write start over bytes
  always_comb begin
    if (rd_start)               op = OP_RD_START;
    else if (wr_start)          op = OP_WR_START;
    else if (rx_valid && pend_q) op = OP_ADDR;
    else if (rx_valid)          op = OP_DATA;
    else if (tx_req)            op = OP_TX;
    else                        op = OP_IDLE;
  end

  always_comb begin
    ptr_d  = ptr_q;
    fmt_d  = fmt_q;
    pend_d = pend_q;
    unique case (op)
      OP_RD_START: begin
        ptr_d  = PW'(NUM_REGS - 1);
        pend_d = 1'b0;
      end
      OP_WR_START: pend_d = 1'b1;
      OP_ADDR: begin
        ptr_d  = rx_byte[DW-1 -: PW];
        fmt_d  = rx_byte[FMT_W-1:0];
        pend_d = 1'b0;
      end
      OP_DATA, OP_TX: ptr_d = ptr_q + PW'(1);
      default: ;
    endcase
  end

  assign data_we = (op == OP_DATA);
  assign snap_en = (op == OP_RD_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fmt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      fmt_q  <= fmt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/rtc_fe_regs.sv
module rtc_fe_regs #(
  parameter int NUM_REGS    = 16,
  parameter int DW          = 8,
  parameter int TIME_FIELDS = 7,
  localparam int PW         = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       snap_en,
  input  logic [TIME_FIELDS*DW-1:0]  time_now,
  input  logic                       gp_we,
  input  logic [PW-1:0]              ptr,
  input  logic [DW-1:0]              wdata,
  output logic [NUM_REGS-1:0][DW-1:0] regs_q
);
  logic [NUM_REGS-1:0][DW-1:0] regs_d;
  logic [NUM_REGS-1:0]         reg_en;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    if (i < TIME_FIELDS) begin : g_snap
      assign reg_en[i] = snap_en;
      assign regs_d[i] = time_now[i*DW +: DW];
    end else begin : g_gp
      assign reg_en[i] = gp_we && (ptr == PW'(i));
      assign regs_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[i] <= '0;
      else if (reg_en[i]) regs_q[i] <= regs_d[i];
    end
  end
endmodule

// File: rtl/rtc_bus_frontend.sv
module rtc_bus_frontend #(
  parameter int         NUM_REGS    = 16,
  parameter int         DW          = 8,
  parameter int         TIME_FIELDS = 7,
  parameter int         FMT_W       = 4,
  parameter logic [6:0] BUS_ADDR    = 7'h32,
  localparam int        PW          = $clog2(NUM_REGS),
  localparam int        TIW         = $clog2(TIME_FIELDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_start,
  input  logic                      rd_start,
  input  logic                      rx_valid,
  input  logic [DW-1:0]             rx_byte,
  input  logic                      tx_req,
  output logic [DW-1:0]             tx_byte,
  output logic [FMT_W-1:0]          xfer_fmt,
  input  logic [TIME_FIELDS*DW-1:0] time_now,
  output logic                      time_wr_en,
  output logic [TIW-1:0]            time_wr_idx,
  output logic [DW-1:0]             time_wr_data,
  output logic [6:0]                dev_addr
);
  logic [PW-1:0]               ptr_q;
  logic                        pend_q;
  logic                        data_we;
  logic                        snap_en;
  logic                        in_time;
  logic [NUM_REGS-1:0][DW-1:0] regs_q;

  rtc_fe_ptr #(.NUM_REGS(NUM_REGS), .DW(DW), .FMT_W(FMT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .ptr_q(ptr_q), .fmt_q(xfer_fmt), .pend_q(pend_q),
    .data_we(data_we), .snap_en(snap_en)
  );

  assign in_time = (ptr_q < PW'(TIME_FIELDS));

  rtc_fe_regs #(.NUM_REGS(NUM_REGS), .DW(DW), .TIME_FIELDS(TIME_FIELDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .snap_en(snap_en), .time_now(time_now),
    .gp_we(data_we && !in_time), .ptr(ptr_q), .wdata(rx_byte),
    .regs_q(regs_q)
  );

  assign time_wr_en   = data_we && in_time;
  assign time_wr_idx  = ptr_q[TIW-1:0];
  assign time_wr_data = rx_byte;
  assign tx_byte      = regs_q[ptr_q];
  assign dev_addr     = BUS_ADDR;
endmodule

// File: rtl/rtc_bus_frontend_chk.sv
module rtc_bus_frontend_chk #(
  parameter int NUM_REGS    = 16,
  parameter int DW          = 8,
  parameter int TIME_FIELDS = 7,
  parameter int FMT_W       = 4,
  localparam int PW         = $clog2(NUM_REGS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_start,
  input logic                       rd_start,
  input logic                       rx_valid,
  input logic [DW-1:0]              rx_byte,
  input logic                       tx_req,
  input logic [PW-1:0]              ptr_q,
  input logic                       pend_q,
  input logic [FMT_W-1:0]           xfer_fmt,
  input logic [NUM_REGS-1:0][DW-1:0] regs_q,
  input logic [TIME_FIELDS*DW-1:0]  time_now,
  input logic                       time_wr_en
);
  logic no_start;
  logic gp_write;
  assign no_start = !rd_start && !wr_start;
  assign gp_write = rx_valid && !pend_q && no_start && (ptr_q >= PW'(TIME_FIELDS));

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pend_q && no_start) |=>
      (ptr_q == $past(rx_byte[DW-1 -: PW]) && xfer_fmt == $past(rx_byte[FMT_W-1:0])));

  p_data_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !pend_q && no_start) |=> (ptr_q == $past(ptr_q) + PW'(1)));

  p_time_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_en |-> (ptr_q < PW'(TIME_FIELDS) && !pend_q && rx_valid));

  p_gp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gp_write |=> $stable(regs_q[NUM_REGS-1:TIME_FIELDS]));

  p_snap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (ptr_q == PW'(NUM_REGS - 1) &&
                  regs_q[TIME_FIELDS-1:0] == $past(time_now)));

  p_tx_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && no_start && !rx_valid) |=> (ptr_q == $past(ptr_q) + PW'(1)));

  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(regs_q[TIME_FIELDS-1:0]));
endmodule

bind rtc_bus_frontend rtc_bus_frontend_chk #(
  .NUM_REGS(NUM_REGS), .DW(DW), .TIME_FIELDS(TIME_FIELDS), .FMT_W(FMT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
  .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
  .ptr_q(ptr_q), .pend_q(pend_q), .xfer_fmt(xfer_fmt), .regs_q(regs_q),
  .time_now(time_now), .time_wr_en(time_wr_en)
);

// File: tb/rtc_bus_frontend_test.sv
module rtc_bus_frontend_test;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_start, rd_start, rx_valid, tx_req;
  logic [7:0]  rx_byte;
  logic [7:0]  tx_byte;
  logic [3:0]  xfer_fmt;
  logic [55:0] time_now;
  logic        time_wr_en;
  logic [2:0]  time_wr_idx;
  logic [7:0]  time_wr_data;
  logic [6:0]  dev_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [16];
  logic [3:0] bptr;
  logic       bpend;
  bit         finished = 0;

  rtc_bus_frontend uut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_byte(tx_byte), .xfer_fmt(xfer_fmt), .time_now(time_now),
    .time_wr_en(time_wr_en), .time_wr_idx(time_wr_idx),
    .time_wr_data(time_wr_data), .dev_addr(dev_addr)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [55:0] tpat(input logic [7:0] base);
    logic [55:0] v;
    for (int i = 0; i < 7; i++) v[i*8 +: 8] = base + 8'(i * 3);
    return v;
  endfunction

  task automatic bus_wr_start();
    wr_start = 1'b1; step(); wr_start = 1'b0;
    bpend = 1'b1;
  endtask

  task automatic bus_send(input logic [7:0] b);
    logic       te;
    logic [2:0] ti;
    logic [7:0] td;
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    te = time_wr_en; ti = time_wr_idx; td = time_wr_data;
    step();
    rx_valid = 1'b0;
    if (bpend) begin
      bpend = 1'b0;
      bptr  = b[7:4];
      chk("R2", "addr byte raises no time write", int'(te), 0);
      chk("R2", "format code", int'(xfer_fmt), int'(b[3:0]));
    end else begin
      if (bptr < 4'd7) begin
        chk("R4", "time write strobe", int'(te), 1);
        chk("R4", "time write index", int'(ti), int'(bptr));
        chk("R4", "time write data", int'(td), int'(b));
      end else begin
        chk("R5", "no time write for general index", int'(te), 0);
        mdl[bptr] = b;
      end
      bptr = bptr + 4'd1;
    end
  endtask

  task automatic bus_rd_start();
    rd_start = 1'b1; step(); rd_start = 1'b0;
    for (int i = 0; i < 7; i++) mdl[i] = time_now[i*8 +: 8];
    bptr = 4'hF;
  endtask

  task automatic bus_read(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      tx_req = 1'b1;
      @(negedge clk);
      chk(req, $sformatf("read byte idx %0d", bptr), int'(tx_byte), int'(mdl[bptr]));
      step();
      tx_req = 1'b0;
      bptr = bptr + 4'd1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "tx_byte in reset", int'(tx_byte), 0);
    chk("R1", "format in reset", int'(xfer_fmt), 0);
    chk("R1", "time strobe in reset", int'(time_wr_en), 0);
    chk("R10", "bus address", int'(dev_addr), 'h32);
    step(); rst_n = 1'b1; step();
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    bptr = 4'h0; bpend = 1'b0;
    // pointer 0 after reset: a data byte with no address byte goes to time field 0
    bus_send(8'h37);
    bus_rd_start();
    bus_read(16, "R1");
  endtask

  task automatic t_gp_write();
    bus_wr_start();
    bus_send(8'h7A);
    bus_send(8'h11);
    bus_send(8'h22);
    bus_send(8'hC3);
    time_now = tpat(8'h10);
    bus_rd_start();
    bus_read(16, "R7");
  endtask

  task automatic t_time_write();
    bus_wr_start();
    bus_send(8'h25);
    bus_send(8'h09);
    bus_send(8'h13);
    bus_send(8'h06);
    bus_rd_start();
    bus_read(10, "R4");
  endtask

  task automatic t_wrap_write();
    bus_wr_start();
    bus_send(8'hE3);
    bus_send(8'hA5);
    bus_send(8'h5A);
    bus_send(8'h44);
    bus_rd_start();
    bus_read(17, "R3");
  endtask

  task automatic t_snapshot_hold();
    time_now = tpat(8'h40);
    bus_rd_start();
    time_now = tpat(8'h80);
    bus_read(8, "R8");
    step();
    bus_read(4, "R8");
    bus_rd_start();
    bus_read(8, "R6");
  endtask

  task automatic t_addr_only();
    bus_wr_start();
    bus_send(8'h9C);
    step();
    bus_rd_start();
    bus_read(16, "R9");
    bus_wr_start();
    bus_send(8'h81);
    bus_send(8'h77);
    bus_rd_start();
    bus_read(16, "R9");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_start = 1'b0; rd_start = 1'b0; rx_valid = 1'b0;
    tx_req = 1'b0; rx_byte = 8'h00; time_now = tpat(8'h01);
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_gp_write();
    t_time_write();
    t_wrap_write();
    t_snapshot_hold();
    t_addr_only();
    repeat (2) step();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule